// File: doc/BRIEF.md
# Dual-Mode Multiply/Add Compute Element

This block is a small arithmetic tile for a data-parallel array. On every cycle it can accept one operation. That operation is either a single multiply on a 9-bit signed multiplier or a pair of independent 8-bit add, subtract or bitwise operations on two byte lanes. Each byte lane is built as a carry-select adder. Two sums are formed in parallel, one assuming a carry of 0 and one assuming a carry of 1, and the incoming carry picks between them. A third path in each lane handles the bitwise operations.

The two lanes can be joined so that the low lane's carry-out becomes the high lane's carry-in. This turns the pair into one 16-bit adder or subtractor. The multiplier extends each 8-bit operand to 9 bits, using either its top bit or zero, so that every operand can be treated as signed or unsigned. The 18-bit product is registered. A 24-bit running sum can either be loaded with the product or have the product added to it, which allows short multiply-accumulate sequences.

Results appear one cycle after issue, and a valid flag marks them. A small state machine tracks what the output registers are presenting. ST_IDLE means nothing was issued in the previous cycle. ST_ALU means lane results from an add, subtract or bitwise operation. ST_MUL means a product from a multiply or multiply-accumulate. The next state depends only on the current issue, so the state machine has these transitions from every state:
- T_ISSUE_ALU goes to ST_ALU when a lane operation is issued.
- T_ISSUE_MUL goes to ST_MUL when a multiply operation is issued.
- T_NONE goes to ST_IDLE when no issue is made or the reserved opcode is issued.

Top module: `dualmode_pe`

## Requirements
- R1: After reset, every output register is zero, `valid` is 0 and `kind` is 0.
- R2: A legal opcode issued in one cycle gives `valid`=1 in the next cycle. If no issue is made, or the reserved opcode 7 is issued, the next cycle has `valid`=0 and `res_lo`, `res_hi`, `cout_lo`, `cout_hi`, `prod` and `acc` keep their values.
- R3: Opcode 0 (add) gives each lane the result a+b+carry-in modulo 256. The lane's carry-out is bit 8 of that sum.
- R4: Opcode 1 (subtract) gives each lane the result a+(~b)+carry-in modulo 256, with carry-out as bit 8. With a carry-in of 1 this is a-b, and a carry-out of 1 means no borrow.
- R5: With `chain`=0, both lanes take `cin` as their carry-in. With `chain`=1, the high lane's carry-in is the low lane's carry-out, so {res_hi,res_lo} is a 16-bit add or subtract.
- R6: Opcodes 2, 3 and 4 give lane-wise AND, OR and XOR respectively, and set both carry-outs to 0.
- R7: Opcode 5 (multiply) sets `prod` to the 18-bit two's-complement product of a_lo and b_lo. Before the multiply, each operand is extended to 9 bits with its bit 7 if its signed flag is 1, or with 0 if its signed flag is 0. `acc` is loaded with `prod` sign-extended to 24 bits.
- R8: Opcode 6 (multiply-accumulate) sets `prod` as in R7 and adds `prod`, sign-extended to 24 bits, to `acc`, wrapping modulo 2^24.
- R9: Lane operations leave `prod` and `acc` unchanged. Multiply operations leave `res_lo`, `res_hi`, `cout_lo` and `cout_hi` unchanged.
- R10: `kind` reports the state: 0 for ST_IDLE, 1 for ST_ALU, 2 for ST_MUL. `valid` is 1 exactly when `kind` is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Start an operation this cycle |
| op | input | 3 | Opcode (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 mul, 6 mac, 7 reserved) |
| chain | input | 1 | Join the low-lane carry into the high lane |
| cin | input | 1 | Carry-in |
| sgn_a | input | 1 | Treat multiplier operand a as signed |
| sgn_b | input | 1 | Treat multiplier operand b as signed |
| a_lo | input | 8 | Low-lane operand a and multiplier operand a |
| b_lo | input | 8 | Low-lane operand b and multiplier operand b |
| a_hi | input | 8 | High-lane operand a |
| b_hi | input | 8 | High-lane operand b |
| valid | output | 1 | A result from the previous cycle's issue is presented |
| kind | output | 2 | State: 0 idle, 1 lane result, 2 product |
| res_lo | output | 8 | Low-lane result |
| res_hi | output | 8 | High-lane result |
| cout_lo | output | 1 | Low-lane carry-out |
| cout_hi | output | 1 | High-lane carry-out |
| prod | output | 18 | Registered product |
| acc | output | 24 | Running sum |

## Verification
Two things often happen in the same cycle. First, a new operation can be accepted in the same cycle that the previous result is being presented, including when the mode changes between lane operations and multiplies. Second, in chained mode, the low lane's carry decides the high lane's selection within the same cycle. The stimulus issues operations back to back, with random opcodes, random chain settings and random signed flags. This makes switches between a lane result and a product common, and it drives carries across the lane boundary. Each cycle's outputs are compared with a bench model. The model also checks that the registers the current operation must not touch have kept their values.

// File: rtl/dmpe_pkg.sv
package dmpe_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_MUL = 3'd5,
        OP_MAC = 3'd6,
        OP_RSV = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ALU  = 2'd1,
        ST_MUL  = 2'd2
    } state_e;
endpackage

// File: rtl/dmpe_lane.sv
module dmpe_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         logic_en,
    input  logic [1:0]   lsel,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W-1:0] bx;
    logic [W:0]   sum_c0;
    logic [W:0]   sum_c1;
    logic [W-1:0] lres;

    assign bx     = sub ? ~b : b;
    // adder path assuming carry 0
    assign sum_c0 = {1'b0, a} + {1'b0, bx};
    // adder path assuming carry 1
    assign sum_c1 = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, 1'b1};

    // bitwise path
    always_comb begin
        unique case (lsel)
            2'd0:    lres = a & b;
            2'd1:    lres = a | b;
            default: lres = a ^ b;
        endcase
    end

    assign res  = logic_en ? lres : (cin ? sum_c1[W-1:0] : sum_c0[W-1:0]);
    assign cout = logic_en ? 1'b0 : (cin ? sum_c1[W] : sum_c0[W]);
endmodule

// File: rtl/dmpe_mul.sv
module dmpe_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sa,
    input  logic           sb,
    output logic [2*W+1:0] p
);
    logic signed [W:0]     ax;
    logic signed [W:0]     bx;
    logic signed [2*W+1:0] pf;

    assign ax = {sa & a[W-1], a};
    assign bx = {sb & b[W-1], b};
    assign pf = ax * bx;
    assign p  = pf;
endmodule

// File: rtl/dualmode_pe.sv
module dualmode_pe
    import dmpe_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int ACC_W  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [2:0]            op,
    input  logic                  chain,
    input  logic                  cin,
    input  logic                  sgn_a,
    input  logic                  sgn_b,
    input  logic [LANE_W-1:0]     a_lo,
    input  logic [LANE_W-1:0]     b_lo,
    input  logic [LANE_W-1:0]     a_hi,
    input  logic [LANE_W-1:0]     b_hi,
    output logic                  valid,
    output logic [1:0]            kind,
    output logic [LANE_W-1:0]     res_lo,
    output logic [LANE_W-1:0]     res_hi,
    output logic                  cout_lo,
    output logic                  cout_hi,
    output logic [2*LANE_W+1:0]   prod,
    output logic [ACC_W-1:0]      acc
);
    localparam int NLANE  = 2;
    localparam int PROD_W = 2 * (LANE_W + 1);
    localparam int EXT_W  = ACC_W - PROD_W;

    op_e    op_q;
    state_e state, state_nx;
    logic   legal, is_mul, is_alu, is_sub, is_logic;
    logic [1:0] lsel;

    logic [LANE_W-1:0] la [NLANE];
    logic [LANE_W-1:0] lb [NLANE];
    logic [LANE_W-1:0] lr [NLANE];
    logic              lci [NLANE];
    logic              lco [NLANE];
    logic [PROD_W-1:0] p_w;
    logic [ACC_W-1:0]  p_ext;

    // ---------------- decode ----------------
    assign op_q     = op_e'(op);
    assign legal    = issue && (op_q != OP_RSV);
    assign is_mul   = (op_q == OP_MUL) || (op_q == OP_MAC);
    assign is_alu   = legal && !is_mul;
    assign is_sub   = (op_q == OP_SUB);
    assign is_logic = (op_q == OP_AND) || (op_q == OP_OR) || (op_q == OP_XOR);
    assign lsel     = (op_q == OP_AND) ? 2'd0 : (op_q == OP_OR) ? 2'd1 : 2'd2;

    assign la[0] = a_lo;
    assign lb[0] = b_lo;
    assign la[1] = a_hi;
    assign lb[1] = b_hi;

    // ---------------- lanes ----------------
    generate
        for (genvar i = 0; i < NLANE; i++) begin : g_lane
            if (i == 0) begin : g_first
                assign lci[i] = cin;
            end else begin : g_next
                assign lci[i] = chain ? lco[i-1] : cin;
            end
            dmpe_lane #(.W(LANE_W)) u_lane (
                .a        (la[i]),
                .b        (lb[i]),
                .cin      (lci[i]),
                .sub      (is_sub),
                .logic_en (is_logic),
                .lsel     (lsel),
                .res      (lr[i]),
                .cout     (lco[i])
            );
        end
    endgenerate

    // ---------------- multiplier ----------------
    dmpe_mul #(.W(LANE_W)) u_mul (
        .a  (a_lo),
        .b  (b_lo),
        .sa (sgn_a),
        .sb (sgn_b),
        .p  (p_w)
    );

    assign p_ext = {{EXT_W{p_w[PROD_W-1]}}, p_w};

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_ALU, ST_MUL: begin
                if (legal) state_nx = is_mul ? ST_MUL : ST_ALU;   // T_ISSUE_MUL / T_ISSUE_ALU
                else       state_nx = ST_IDLE;                    // T_NONE
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs from state ----------------
    always_comb begin
        valid = 1'b0;
        kind  = 2'd0;
        unique case (state)
            ST_IDLE: begin valid = 1'b0; kind = 2'd0; end
            ST_ALU:  begin valid = 1'b1; kind = 2'd1; end
            ST_MUL:  begin valid = 1'b1; kind = 2'd2; end
            default: begin valid = 1'b0; kind = 2'd0; end
        endcase
    end

    // ---------------- result registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo  <= '0;
            res_hi  <= '0;
            cout_lo <= 1'b0;
            cout_hi <= 1'b0;
        end else if (is_alu) begin
            res_lo  <= lr[0];
            res_hi  <= lr[1];
            cout_lo <= lco[0];
            cout_hi <= lco[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
            acc  <= '0;
        end else if (legal && is_mul) begin
            prod <= p_w;
            if (op_q == OP_MAC) acc <= acc + p_ext;
            else                acc <= p_ext;
        end
    end
endmodule

// File: rtl/dmpe_chk.sv
module dmpe_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue,
    input logic [2:0]  op,
    input logic        valid,
    input logic [1:0]  kind,
    input logic [7:0]  res_lo,
    input logic [7:0]  res_hi,
    input logic        cout_lo,
    input logic        cout_hi,
    input logic [17:0] prod,
    input logic [23:0] acc
);
    assert_valid_after_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op != 3'd7) |=> valid);

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && op != 3'd7) |=> (!valid && $stable(res_lo) && $stable(res_hi)
                                    && $stable(prod) && $stable(acc)));

    assert_logic_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op == 3'd2 || op == 3'd3 || op == 3'd4)) |=> (!cout_lo && !cout_hi));

    assert_mac_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 3'd6) |=> (acc == $past(acc) + {{6{prod[17]}}, prod}));

    assert_alu_keeps_product_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op <= 3'd4) |=> ($stable(prod) && $stable(acc)));

    assert_mul_keeps_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op == 3'd5 || op == 3'd6)) |=> ($stable(res_lo) && $stable(res_hi)
                                                 && $stable(cout_lo) && $stable(cout_hi)));

    assert_kind_matches_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid == (kind != 2'd0));
endmodule

bind dualmode_pe dmpe_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .op      (op),
    .valid   (valid),
    .kind    (kind),
    .res_lo  (res_lo),
    .res_hi  (res_hi),
    .cout_lo (cout_lo),
    .cout_hi (cout_hi),
    .prod    (prod),
    .acc     (acc)
);

// File: tb/tb_dualmode_pe.sv
`timescale 1ns/1ps
module tb_dualmode_pe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        chain = 1'b0, cin = 1'b0, sgn_a = 1'b0, sgn_b = 1'b0;
    logic [7:0]  a_lo = 8'd0, b_lo = 8'd0, a_hi = 8'd0, b_hi = 8'd0;
    logic        valid;
    logic [1:0]  kind;
    logic [7:0]  res_lo, res_hi;
    logic        cout_lo, cout_hi;
    logic [17:0] prod;
    logic [23:0] acc;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0]  m_rlo = 0, m_rhi = 0;
    logic        m_clo = 0, m_chi = 0;
    logic [17:0] m_prod = 0;
    logic [23:0] m_acc = 0;

    always #2.5 clk = ~clk;

    dualmode_pe dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .chain(chain), .cin(cin),
        .sgn_a(sgn_a), .sgn_b(sgn_b), .a_lo(a_lo), .b_lo(b_lo), .a_hi(a_hi), .b_hi(b_hi),
        .valid(valid), .kind(kind), .res_lo(res_lo), .res_hi(res_hi),
        .cout_lo(cout_lo), .cout_hi(cout_hi), .prod(prod), .acc(acc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sx(input logic [7:0] v, input logic s);
        if (s && v[7]) return int'(v) - 256;
        return int'(v);
    endfunction

    // lane model: returns {carry, result}
    function automatic logic [8:0] lane(input logic [7:0] a, input logic [7:0] b,
                                        input logic c, input logic [2:0] o);
        logic [8:0] s;
        case (o)
            3'd0: s = {1'b0, a} + {1'b0, b} + {8'd0, c};
            3'd1: s = {1'b0, a} + {1'b0, ~b} + {8'd0, c};
            3'd2: s = {1'b0, a & b};
            3'd3: s = {1'b0, a | b};
            default: s = {1'b0, a ^ b};
        endcase
        return s;
    endfunction

    task automatic do_op(input bit iss, input logic [2:0] o, input logic ch, input logic ci,
                         input logic sa, input logic sb, input logic [7:0] al,
                         input logic [7:0] bl, input logic [7:0] ah, input logic [7:0] bh);
        logic [8:0] l0, l1;
        int p;
        bit leg;
        string tl;
        @(negedge clk);
        issue = iss; op = o; chain = ch; cin = ci; sgn_a = sa; sgn_b = sb;
        a_lo = al; b_lo = bl; a_hi = ah; b_hi = bh;
        @(posedge clk);
        #1;
        issue = 1'b0;
        leg = iss && (o != 3'd7);
        if (leg && o <= 3'd4) begin
            l0 = lane(al, bl, ci, o);
            l1 = lane(ah, bh, ch ? l0[8] : ci, o);
            m_rlo = l0[7:0]; m_rhi = l1[7:0]; m_clo = l0[8]; m_chi = l1[8];
        end else if (leg) begin
            p = sx(al, sa) * sx(bl, sb);
            m_prod = p[17:0];
            if (o == 3'd6) m_acc = m_acc + p[23:0];
            else           m_acc = p[23:0];
        end
        if (!leg)                     tl = "R2";
        else if (o == 3'd0 && ch)     tl = "R5";
        else if (o == 3'd0)           tl = "R3";
        else if (o == 3'd1)           tl = ch ? "R5" : "R4";
        else if (o <= 3'd4)           tl = "R6";
        else                          tl = "R9";
        chk("R2 valid", {31'd0, valid}, {31'd0, leg});
        chk("R10 kind", {30'd0, kind}, !leg ? 32'd0 : (o >= 3'd5 ? 32'd2 : 32'd1));
        chk({tl, " res_lo"}, {24'd0, res_lo}, {24'd0, m_rlo});
        chk({tl, " res_hi"}, {24'd0, res_hi}, {24'd0, m_rhi});
        chk({tl, " cout_lo"}, {31'd0, cout_lo}, {31'd0, m_clo});
        chk({tl, " cout_hi"}, {31'd0, cout_hi}, {31'd0, m_chi});
        if (!leg)            tl = "R2";
        else if (o == 3'd5)  tl = "R7";
        else if (o == 3'd6)  tl = "R8";
        else                 tl = "R9";
        chk({tl, " prod"}, {14'd0, prod}, {14'd0, m_prod});
        chk({tl, " acc"}, {8'd0, acc}, {8'd0, m_acc});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED1234);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk("R1 valid", {31'd0, valid}, 32'd0);
        chk("R1 kind", {30'd0, kind}, 32'd0);
        chk("R1 res", {16'd0, res_hi, res_lo}, 32'd0);
        chk("R1 carries", {30'd0, cout_hi, cout_lo}, 32'd0);
        chk("R1 prod", {14'd0, prod}, 32'd0);
        chk("R1 acc", {8'd0, acc}, 32'd0);

        // R3: unchained add with carry out of both lanes
        do_op(1, 3'd0, 0, 1, 0, 0, 8'hFF, 8'h00, 8'h80, 8'h80);
        // R4: subtract with borrow
        do_op(1, 3'd1, 0, 1, 0, 0, 8'h05, 8'h07, 8'h07, 8'h05);
        // R5: chained 16-bit subtract 0x0100 - 0x0001
        do_op(1, 3'd1, 1, 1, 0, 0, 8'h00, 8'h01, 8'h01, 8'h00);
        // R5: chained 16-bit add 0x00FF + 0x0001
        do_op(1, 3'd0, 1, 0, 0, 0, 8'hFF, 8'h01, 8'h00, 8'h00);
        // R6: bitwise ops with carry-in set
        do_op(1, 3'd2, 1, 1, 0, 0, 8'hF0, 8'h3C, 8'hAA, 8'hFF);
        do_op(1, 3'd3, 0, 1, 0, 0, 8'hF0, 8'h0F, 8'h00, 8'h00);
        do_op(1, 3'd4, 0, 1, 0, 0, 8'hFF, 8'h0F, 8'h55, 8'hAA);
        // R7: multiply corners
        do_op(1, 3'd5, 0, 0, 1, 1, 8'h80, 8'h80, 8'h00, 8'h00);
        do_op(1, 3'd5, 0, 0, 0, 0, 8'hFF, 8'hFF, 8'h00, 8'h00);
        do_op(1, 3'd5, 0, 0, 1, 0, 8'hFF, 8'hFF, 8'h00, 8'h00);
        do_op(1, 3'd5, 0, 0, 1, 1, 8'h7F, 8'h80, 8'h00, 8'h00);
        // R2: reserved opcode and idle cycle hold everything
        do_op(1, 3'd7, 1, 1, 1, 1, 8'h12, 8'h34, 8'h56, 8'h78);
        do_op(0, 3'd0, 0, 1, 0, 0, 8'h11, 8'h22, 8'h33, 8'h44);
        // R8: long accumulation that wraps past 2^24
        do_op(1, 3'd5, 0, 0, 0, 0, 8'hFF, 8'hFF, 8'h00, 8'h00);
        for (int k = 0; k < 260; k++)
            do_op(1, 3'd6, 0, 0, 0, 0, 8'hFF, 8'hFF, 8'h00, 8'h00);
        // R8: negative accumulation
        for (int k = 0; k < 20; k++)
            do_op(1, 3'd6, 0, 0, 1, 1, 8'h80, 8'h7F, 8'h00, 8'h00);
        // random mix, back to back with mode switches
        for (int k = 0; k < 3000; k++) begin
            do_op(($urandom % 8) != 0, 3'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
                  8'($urandom), 8'($urandom));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule